// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional Pairs

This block holds a single address reservation on behalf of one core so that a load-reserved and a later store-conditional can act as one atomic read-modify-write. The core reports each load-reserved and each store-conditional it issues. Meanwhile, the block watches the write traffic of every other agent on shared memory through a set of snoop ports. The block answers each store-conditional one cycle later. The answer says whether the store may be committed to memory, and gives the value the core must write into the destination register of that store-conditional.

Reservations cover a whole doubleword, which is eight bytes aligned to eight. The reservation is lost when a snooped write touches any byte of the reserved doubleword. It is also consumed by any store-conditional, whether that store succeeds or fails. A load-reserved always installs a new reservation, and the old one, if any, is dropped. The number of snoop ports, the address width and the register width are parameters.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset there is no reservation, so a store-conditional fails, and `sc_rsp_valid` stays low until a store-conditional has been issued.
- R2: A store-conditional to any byte address inside the doubleword of the last load-reserved succeeds when nothing disturbed the reservation in between. Its response shows `sc_rsp_ok`=1 and `sc_rsp_status`=0.
- R3: A store-conditional that fails shows `sc_rsp_ok`=0 and `sc_rsp_status`=1.
- R4: Every store-conditional removes the reservation, whether it succeeds or fails, so a second store-conditional with no load-reserved between the two fails.
- R5: A snooped write kills the reservation when it covers any byte of the reserved doubleword. The write starts at `snp_addr` and is 2^`snp_size` bytes long: code 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes.
- R6: A misaligned snooped write that straddles into the reserved doubleword from the doubleword next to it also kills the reservation. A snooped write that covers no byte of the reserved doubleword has no effect on it.
- R7: A store-conditional to a doubleword other than the reserved one fails.
- R8: A new load-reserved replaces the existing reservation.
- R9: When a store-conditional and a snooped write to the reserved doubleword fall in the same cycle, the store-conditional fails.
- R10: When a load-reserved and a snooped write fall in the same cycle, the write is ordered first. The new reservation is installed either way.
- R11: The response comes exactly one cycle after `sc_req`, and only then. When a load-reserved and a store-conditional fall in the same cycle, the store is judged against the old reservation, and the load then installs its new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_req | input | 1 | Own core issues a load-reserved |
| lr_addr | input | AW | Byte address of the load-reserved |
| sc_req | input | 1 | Own core issues a store-conditional |
| sc_addr | input | AW | Byte address of the store-conditional |
| snp_wr | input | NSNP | Write seen from another agent, one bit per snoop port |
| snp_addr | input | NSNP x AW | Start byte address of each snooped write |
| snp_size | input | NSNP x 2 | Log2 of the byte length of each snooped write |
| sc_rsp_valid | output | 1 | Store-conditional response is present |
| sc_rsp_ok | output | 1 | The store may be committed to memory |
| sc_rsp_status | output | XLEN | Destination register value: 0 on success, 1 on failure |

## Verification
The cases that matter most are those where two events land in the same clock. One is a store-conditional in the same cycle as a foreign write to the reserved doubleword. Another is a load-reserved in the same cycle as a foreign write, aimed either at the new line or at the old one. A third is a load-reserved in the same cycle as a store-conditional. The bench drives each of these pairs on purpose. It also runs a long stretch in which a second agent writes at random into a small set of doublewords while the core races it with reservation pairs on the same lines. Each response is judged against a behavioural model that applies the ordering rules given in R9 to R11.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [1:0] {
        WSZ_BYTE  = 2'd0,
        WSZ_HALF  = 2'd1,
        WSZ_WORD  = 2'd2,
        WSZ_DWORD = 2'd3
    } wsize_e;

    localparam int unsigned SC_FAIL_CODE = 1;

endpackage

// File: rtl/lrsc_hit.sv
module lrsc_hit #(
    parameter int unsigned AW = 32,
    parameter int unsigned GB = 3
) (
    input  logic               wr,
    input  logic [AW-1:0]      addr,
    input  logic [1:0]         size,
    input  logic [AW-GB-1:0]   rsv_tag,
    output logic               hit
);
    localparam int unsigned TW = AW - GB;

    logic [AW-1:0] span;
    logic [AW-1:0] last_addr;
    logic [TW-1:0] first_tag;
    logic [TW-1:0] last_tag;

    always_comb begin
        span      = {{(AW-1){1'b0}}, 1'b1} << size;
        last_addr = addr + span - {{(AW-1){1'b0}}, 1'b1};
        first_tag = addr[AW-1:GB];
        last_tag  = last_addr[AW-1:GB];
        hit       = wr && ((first_tag == rsv_tag) || (last_tag == rsv_tag));
    end

endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
    parameter int unsigned AW   = 32,
    parameter int unsigned XLEN = 64,
    parameter int unsigned GB   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lr_req,
    input  logic [AW-GB-1:0]   lr_tag,
    input  logic               sc_req,
    input  logic [AW-GB-1:0]   sc_tag,
    input  logic               snp_kill,
    output logic               rsv_valid,
    output logic [AW-GB-1:0]   rsv_tag,
    output logic               rsp_valid,
    output logic               rsp_ok,
    output logic [XLEN-1:0]    rsp_status
);
    import lrsc_pkg::*;

    localparam int unsigned TW = AW - GB;
    localparam logic [XLEN-1:0] FAIL_VAL = XLEN'(SC_FAIL_CODE);

    typedef struct packed {
        logic            valid;
        logic [TW-1:0]   tag;
        logic            rv;
        logic            ok;
        logic [XLEN-1:0] status;
    } state_t;

    state_t st_d, st_q;
    logic   kill_live;
    logic   sc_pass;

    always_comb begin
        st_d      = st_q;
        kill_live = st_q.valid && snp_kill;
        sc_pass   = sc_req && st_q.valid && (sc_tag == st_q.tag) && !kill_live;

        st_d.rv     = sc_req;
        st_d.ok     = sc_pass;
        st_d.status = sc_pass ? '0 : FAIL_VAL;
        if (!sc_req) begin
            st_d.ok     = 1'b0;
            st_d.status = '0;
        end

        if (sc_req || kill_live) begin
            st_d.valid = 1'b0;
        end
        if (lr_req) begin
            st_d.valid = 1'b1;
            st_d.tag   = lr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsv_valid  = st_q.valid;
    assign rsv_tag    = st_q.tag;
    assign rsp_valid  = st_q.rv;
    assign rsp_ok     = st_q.ok;
    assign rsp_status = st_q.status;

    // R11: a response follows each store-conditional and nothing else
    p_rsp_after_sc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> rsp_valid);
    p_no_stray_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_req |=> !rsp_valid);
    // R3: a failed response carries the failure code
    p_fail_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (rsp_status == FAIL_VAL));
    // R2: success reports zero
    p_ok_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok) |-> (rsp_status == '0));
    // R4: a store-conditional consumes the reservation
    p_sc_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !lr_req) |=> !rsv_valid);
    // R8: a load-reserved installs its own line
    p_lr_installs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lr_req |=> (rsv_valid && rsv_tag == $past(lr_tag)));
    // R5: a snooped hit drops a live reservation
    p_snoop_kills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_valid && snp_kill && !lr_req) |=> !rsv_valid);
    // R1: no success without a live reservation
    p_no_pass_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !rsv_valid) |=> !rsp_ok);

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
    parameter int unsigned AW   = 32,
    parameter int unsigned XLEN = 64,
    parameter int unsigned NSNP = 2,
    parameter int unsigned GB   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lr_req,
    input  logic [AW-1:0]              lr_addr,
    input  logic                       sc_req,
    input  logic [AW-1:0]              sc_addr,
    input  logic [NSNP-1:0]            snp_wr,
    input  logic [NSNP-1:0][AW-1:0]    snp_addr,
    input  logic [NSNP-1:0][1:0]       snp_size,
    output logic                       sc_rsp_valid,
    output logic                       sc_rsp_ok,
    output logic [XLEN-1:0]            sc_rsp_status
);
    localparam int unsigned TW = AW - GB;

    logic [NSNP-1:0] port_hit;
    logic            any_hit;
    logic            rsv_valid;
    logic [TW-1:0]   rsv_tag;

    for (genvar g = 0; g < NSNP; g++) begin : g_snoop
        lrsc_hit #(.AW(AW), .GB(GB)) i_hit (
            .wr      (snp_wr[g]),
            .addr    (snp_addr[g]),
            .size    (snp_size[g]),
            .rsv_tag (rsv_tag),
            .hit     (port_hit[g])
        );
    end

    assign any_hit = |port_hit;

    lrsc_resv #(.AW(AW), .XLEN(XLEN), .GB(GB)) i_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .lr_req     (lr_req),
        .lr_tag     (lr_addr[AW-1:GB]),
        .sc_req     (sc_req),
        .sc_tag     (sc_addr[AW-1:GB]),
        .snp_kill   (any_hit),
        .rsv_valid  (rsv_valid),
        .rsv_tag    (rsv_tag),
        .rsp_valid  (sc_rsp_valid),
        .rsp_ok     (sc_rsp_ok),
        .rsp_status (sc_rsp_status)
    );

endmodule

// File: tb/test_lrsc_monitor.sv
module test_lrsc_monitor;
    localparam int AW = 32;
    localparam int XLEN = 64;
    localparam int NSNP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lr_req = 1'b0;
    logic [AW-1:0] lr_addr = '0;
    logic sc_req = 1'b0;
    logic [AW-1:0] sc_addr = '0;
    logic [NSNP-1:0] snp_wr = '0;
    logic [NSNP-1:0][AW-1:0] snp_addr = '0;
    logic [NSNP-1:0][1:0] snp_size = '0;
    logic sc_rsp_valid, sc_rsp_ok;
    logic [XLEN-1:0] sc_rsp_status;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    bit m_valid = 0;
    logic [AW-1:0] m_line = '0;
    bit e_rv = 0, e_ok = 0;

    always #2 clk = ~clk;

    lrsc_monitor #(.AW(AW), .XLEN(XLEN), .NSNP(NSNP)) i_lrsc_monitor (
        .clk(clk), .rst_n(rst_n), .lr_req(lr_req), .lr_addr(lr_addr),
        .sc_req(sc_req), .sc_addr(sc_addr), .snp_wr(snp_wr),
        .snp_addr(snp_addr), .snp_size(snp_size), .sc_rsp_valid(sc_rsp_valid),
        .sc_rsp_ok(sc_rsp_ok), .sc_rsp_status(sc_rsp_status)
    );

    task automatic check(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit touches(logic [AW-1:0] a, logic [1:0] sz, logic [AW-1:0] line);
        logic [AW-1:0] e;
        e = a + ((32'd1 << sz) - 32'd1);
        return ((a / 8) == line) || ((e / 8) == line);
    endfunction

    task automatic step();
        bit kill;
        @(posedge clk);
        kill = 0;
        for (int p = 0; p < NSNP; p++)
            if (snp_wr[p] && m_valid && touches(snp_addr[p], snp_size[p], m_line)) kill = 1;
        e_rv = sc_req;
        e_ok = sc_req && m_valid && ((sc_addr / 8) == m_line) && !kill;
        if (sc_req || kill) m_valid = 0;
        if (lr_req) begin m_valid = 1; m_line = lr_addr / 8; end
        @(negedge clk);
        check(cur_req, "rsp_valid", XLEN'(sc_rsp_valid), XLEN'(e_rv));
        if (e_rv) begin
            check(cur_req, "rsp_ok", XLEN'(sc_rsp_ok), XLEN'(e_ok));
            check(cur_req, "rsp_status", sc_rsp_status, e_ok ? '0 : XLEN'(1));
        end
        lr_req = 0; sc_req = 0; snp_wr = '0;
    endtask

    task automatic do_lr(logic [AW-1:0] a);
        lr_req = 1; lr_addr = a; step();
    endtask

    task automatic snoop(int p, logic [AW-1:0] a, logic [1:0] sz);
        snp_wr[p] = 1; snp_addr[p] = a; snp_size[p] = sz;
    endtask

    task automatic do_sc(logic [AW-1:0] a, bit exp_ok, string req);
        sc_req = 1; sc_addr = a; step();
        check(req, "sc outcome", XLEN'(sc_rsp_ok), XLEN'(exp_ok));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "rsp_valid in reset", XLEN'(sc_rsp_valid), '0);
        rst_n = 1;
        cur_req = "R1"; step(); step();
        check("R1", "rsp_valid idle", XLEN'(sc_rsp_valid), '0);
        do_sc(32'h100, 0, "R1");

        cur_req = "R2"; do_lr(32'h100); step();
        do_sc(32'h105, 1, "R2");
        check("R2", "status zero", sc_rsp_status, '0);
        cur_req = "R4"; do_sc(32'h100, 0, "R4");
        check("R3", "status one", sc_rsp_status, XLEN'(1));

        cur_req = "R5"; do_lr(32'h200); snoop(1, 32'h207, 2'd0); step();
        do_sc(32'h200, 0, "R5");
        do_lr(32'h200); snoop(0, 32'h200, 2'd3); step();
        do_sc(32'h200, 0, "R5");
        cur_req = "R6"; do_lr(32'h200);
        snoop(0, 32'h1F8, 2'd3); snoop(1, 32'h208, 2'd1); step();
        do_sc(32'h204, 1, "R6");
        do_lr(32'h200); snoop(0, 32'h1FE, 2'd2); step();
        do_sc(32'h200, 0, "R6");

        cur_req = "R7"; do_lr(32'h300); do_sc(32'h308, 0, "R7");
        do_sc(32'h300, 0, "R7");

        cur_req = "R8"; do_lr(32'h300); do_lr(32'h400); do_sc(32'h300, 0, "R8");
        do_lr(32'h300); do_lr(32'h400); do_sc(32'h400, 1, "R8");

        cur_req = "R9"; do_lr(32'h500); snoop(1, 32'h503, 2'd0); do_sc(32'h500, 0, "R9");
        do_lr(32'h500); snoop(1, 32'h5A0, 2'd3); do_sc(32'h500, 1, "R9");

        cur_req = "R10"; snoop(0, 32'h600, 2'd3); do_lr(32'h600); do_sc(32'h600, 1, "R10");
        do_lr(32'h600); snoop(0, 32'h600, 2'd3); do_lr(32'h700); do_sc(32'h700, 1, "R10");

        cur_req = "R11"; do_lr(32'h800); lr_req = 1; lr_addr = 32'h900;
        do_sc(32'h800, 1, "R11");
        do_sc(32'h900, 1, "R11");
        step();
        check("R11", "no response without sc", XLEN'(sc_rsp_valid), '0);

        cur_req = "R6";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 3) begin lr_req = 1; lr_addr = 32'h1000 + 32'($urandom_range(0, 23)); end
            if (r >= 3 && r < 6) begin sc_req = 1; sc_addr = 32'h1000 + 32'($urandom_range(0, 23)); end
            if ($urandom_range(0, 3) == 0)
                snoop(int'($urandom_range(0, 1)), 32'h0FFC + 32'($urandom_range(0, 31)), 2'($urandom_range(0, 3)));
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule